// File: doc/BRIEF.md
# Coherent Out-of-Order Counter Incrementer

The block keeps no counters of its own. It reaches an array of 32-bit counters in external memory through an AXI4 master port with 32-bit addresses, 64-bit data and 6-bit IDs. A request on the input stream names a counter index. The block reads that counter, adds one, writes the sum back, and reports the index with the new value on the output stream once the memory has acknowledged the write.

Read data and write responses may come back in any order. Each in-flight request owns one AXI ID from a pool of 64. The read data is captured by ID. Requests are then taken into a short load / write-back pipeline in the order they were accepted.

Two requests to the same counter can be in flight together only if they were accepted back to back. The later one issues no read. When it reaches write-back, it takes the sum of its predecessor, either from the write-back stage or from a one-word history of the last write. Any other request that names a counter still in flight is held off at the input until that counter's writes have been acknowledged. Results therefore match applying the increments in request order.

Top module: `ooo_counter_incr`

## Requirements
- R1: After reset, no AR, AW, W or output-stream valid is asserted, and `din_ready` is high for any index.
- R2: Each accepted request produces exactly one output beat. It carries the same index and a count one above the counter's value before that request, and the counter in memory is left incremented.
- R3: Read and write addresses are the index times 8. Every burst is a single beat: length 0, size code 3 (8 bytes), burst code 1 (incrementing). AR and AW stay stable while they wait for ready.
- R4: Write data holds the new count in bits 31:0 and zeros in bits 63:32, with all 8 strobe bits and WLAST set. Read data is expected to carry zeros in bits 63:32.
- R5: The output beat for a request is emitted only after the write response for that request's ID has been received.
- R6: Read data and write responses are matched by ID in any order. For n requests to one counter starting at value v, the outputs for that counter are exactly v+1 … v+n, each once, and the memory ends at v+n.
- R7: A request naming the same counter as the request accepted just before it, while that one is still unacknowledged, issues no read. It takes the predecessor's sum instead.
- R8: A request naming a counter that is still in flight, other than through the back-to-back case of R7, is held off (`din_ready` low) until those writes are acknowledged. Requests to other counters are not held off.
- R9: At most 64 requests are outstanding. With all 64 IDs in use, `din_ready` is low until a write response frees one.
- R10: While the output beat waits for `dout_ready`, it stays stable and `m_bready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_valid | input | 1 | Request valid |
| din_ready | output | 1 | Request accepted when high with valid |
| din_idx | input | 29 | Counter index |
| dout_valid | output | 1 | Result valid |
| dout_ready | input | 1 | Result consumer ready |
| dout_idx | output | 29 | Index of the incremented counter |
| dout_cnt | output | 32 | Counter value after the increment |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read byte address |
| m_arid | output | 6 | Read ID |
| m_arlen | output | 8 | Read burst length (0) |
| m_arsize | output | 3 | Read beat size code (3) |
| m_arburst | output | 2 | Read burst type (1) |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready (always high) |
| m_rid | input | 6 | Read data ID |
| m_rdata | input | 64 | Read data |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write byte address |
| m_awid | output | 6 | Write ID |
| m_awlen | output | 8 | Write burst length (0) |
| m_awsize | output | 3 | Write beat size code (3) |
| m_awburst | output | 2 | Write burst type (1) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bid | input | 6 | Write response ID |

## Verification
The bench's memory model picks pending read and write responses at random and stalls every ready. Results for one counter therefore return out of order, and any lost or doubled increment shows up as a repeated or missing value in the per-counter sequence and as a wrong final memory word. Holding write responses back separates four cases. A design that forwards incorrectly re-reads memory for a back-to-back pair and counts one increment twice. A design without the collision hold lets an A-B-A pattern read a stale value. A design that ignores the ID pool accepts a 65th request. A design that emits results early produces an output before any write response exists. A high index checks the address shift at the top of the address range. Output backpressure checks that results are neither dropped nor changed while they wait.

// File: rtl/ooo_counter_incr.sv
module ooo_counter_incr #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 6,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din_valid,
  output logic                 din_ready,
  input  logic [ADDR_W-4:0]    din_idx,
  output logic                 dout_valid,
  input  logic                 dout_ready,
  output logic [ADDR_W-4:0]    dout_idx,
  output logic [CNT_W-1:0]     dout_cnt,
  output logic                 m_arvalid,
  input  logic                 m_arready,
  output logic [ADDR_W-1:0]    m_araddr,
  output logic [ID_W-1:0]      m_arid,
  output logic [7:0]           m_arlen,
  output logic [2:0]           m_arsize,
  output logic [1:0]           m_arburst,
  input  logic                 m_rvalid,
  output logic                 m_rready,
  input  logic [ID_W-1:0]      m_rid,
  input  logic [DATA_W-1:0]    m_rdata,
  output logic                 m_awvalid,
  input  logic                 m_awready,
  output logic [ADDR_W-1:0]    m_awaddr,
  output logic [ID_W-1:0]      m_awid,
  output logic [7:0]           m_awlen,
  output logic [2:0]           m_awsize,
  output logic [1:0]           m_awburst,
  output logic                 m_wvalid,
  input  logic                 m_wready,
  output logic [DATA_W-1:0]    m_wdata,
  output logic [DATA_W/8-1:0]  m_wstrb,
  output logic                 m_wlast,
  input  logic                 m_bvalid,
  output logic                 m_bready,
  input  logic [ID_W-1:0]      m_bid
);
  localparam int OFS   = $clog2(DATA_W/8);
  localparam int IDX_W = ADDR_W - OFS;
  localparam int IDS   = 1 << ID_W;

  // per-ID transaction table
  logic [IDS-1:0]   busy, got, fwd;
  logic [IDX_W-1:0] t_idx [IDS];
  logic [CNT_W-1:0] t_val [IDS];

  // acceptance-order queue of IDs
  logic [ID_W-1:0] q [IDS];
  logic [ID_W:0]   q_wp, q_rp;

  logic            last_v;
  logic [ID_W-1:0] last_id;

  logic              ar_v;
  logic [ID_W-1:0]   ar_id;
  logic [ADDR_W-1:0] ar_addr;

  logic              s2_v;
  logic [ID_W-1:0]   s2_id;
  logic              s3_v, aw_done, w_done;
  logic [ID_W-1:0]   s3_id;
  logic [IDX_W-1:0]  s3_idx, h_idx;
  logic [CNT_W-1:0]  s3_val, h_val;

  logic              do_v;
  logic [IDX_W-1:0]  do_idx;
  logic [CNT_W-1:0]  do_cnt;

  // free-ID pick, lowest first
  logic            have_free;
  logic [ID_W-1:0] free_id;
  always_comb begin
    have_free = 1'b0;
    free_id   = '0;
    for (int i = IDS - 1; i >= 0; i--)
      if (!busy[i]) begin
        have_free = 1'b1;
        free_id   = i[ID_W-1:0];
      end
  end

  // collision detection against in-flight entries
  logic [IDS-1:0] hit;
  always_comb
    for (int i = 0; i < IDS; i++)
      hit[i] = busy[i] && (t_idx[i] == din_idx);

  wire chain    = last_v && busy[last_id] && (t_idx[last_id] == din_idx);
  wire conflict = (|hit) && !chain;
  wire ar_free  = !ar_v || m_arready;

  assign din_ready = have_free && !conflict && ar_free;
  wire accept = din_valid && din_ready;

  // pipeline control
  wire [ID_W-1:0] hd    = q[q_rp[ID_W-1:0]];
  wire            hd_ok = (q_wp != q_rp) && (got[hd] || fwd[hd]);
  wire s3_leave = s3_v && (aw_done || m_awready) && (w_done || m_wready);
  wire s2_mv    = s2_v && (!s3_v || s3_leave);
  wire hd_mv    = hd_ok && (!s2_v || s2_mv);
  wire b_fire   = m_bvalid && m_bready;

  wire [CNT_W-1:0] base = fwd[s2_id] ? (s3_v ? s3_val : h_val) : t_val[s2_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      got     <= '0;
      fwd     <= '0;
      q_wp    <= '0;
      q_rp    <= '0;
      last_v  <= 1'b0;
      last_id <= '0;
      ar_v    <= 1'b0;
      ar_id   <= '0;
      ar_addr <= '0;
      s2_v    <= 1'b0;
      s2_id   <= '0;
      s3_v    <= 1'b0;
      s3_id   <= '0;
      s3_idx  <= '0;
      s3_val  <= '0;
      aw_done <= 1'b0;
      w_done  <= 1'b0;
      h_idx   <= '0;
      h_val   <= '0;
      do_v    <= 1'b0;
      do_idx  <= '0;
      do_cnt  <= '0;
    end else begin
      if (m_rvalid) got[m_rid] <= 1'b1;
      if (b_fire) busy[m_bid] <= 1'b0;

      if (ar_v && m_arready) ar_v <= 1'b0;
      if (accept) begin
        busy[free_id] <= 1'b1;
        got[free_id]  <= 1'b0;
        fwd[free_id]  <= chain;
        q_wp          <= q_wp + 1'b1;
        last_v        <= 1'b1;
        last_id       <= free_id;
        if (!chain) begin
          ar_v    <= 1'b1;
          ar_id   <= free_id;
          ar_addr <= {din_idx, {OFS{1'b0}}};
        end
      end

      if (hd_mv) begin
        s2_v  <= 1'b1;
        s2_id <= hd;
        q_rp  <= q_rp + 1'b1;
      end else if (s2_mv) s2_v <= 1'b0;

      if (s2_mv) begin
        s3_v    <= 1'b1;
        s3_id   <= s2_id;
        s3_idx  <= t_idx[s2_id];
        s3_val  <= base + 1'b1;
        aw_done <= 1'b0;
        w_done  <= 1'b0;
      end else if (s3_leave) s3_v <= 1'b0;
      else if (s3_v) begin
        aw_done <= aw_done || m_awready;
        w_done  <= w_done || m_wready;
      end

      if (s3_leave) begin
        h_idx <= s3_idx;
        h_val <= s3_val;
      end

      if (b_fire) begin
        do_v   <= 1'b1;
        do_idx <= t_idx[m_bid];
        do_cnt <= t_val[m_bid];
      end else if (dout_ready) do_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      t_idx[free_id]        <= din_idx;
      q[q_wp[ID_W-1:0]]     <= free_id;
    end
    if (m_rvalid) t_val[m_rid] <= m_rdata[CNT_W-1:0];
    if (s3_leave) t_val[s3_id] <= s3_val;
  end

  assign m_arvalid = ar_v;
  assign m_araddr  = ar_addr;
  assign m_arid    = ar_id;
  assign m_arlen   = 8'd0;
  assign m_arsize  = OFS[2:0];
  assign m_arburst = 2'd1;
  assign m_rready  = 1'b1;

  assign m_awvalid = s3_v && !aw_done;
  assign m_awaddr  = {s3_idx, {OFS{1'b0}}};
  assign m_awid    = s3_id;
  assign m_awlen   = 8'd0;
  assign m_awsize  = OFS[2:0];
  assign m_awburst = 2'd1;
  assign m_wvalid  = s3_v && !w_done;
  assign m_wdata   = {{(DATA_W-CNT_W){1'b0}}, s3_val};
  assign m_wstrb   = '1;
  assign m_wlast   = 1'b1;
  assign m_bready  = !do_v || dout_ready;

  assign dout_valid = do_v;
  assign dout_idx   = do_idx;
  assign dout_cnt   = do_cnt;

  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arid));

  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awid) && $stable(m_wdata));

  assert_rd_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> m_rdata[DATA_W-1:CNT_W] == '0);

  assert_r_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> busy[m_rid] && !fwd[m_rid] && !got[m_rid]);

  assert_b_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid |-> busy[m_bid] && !(s3_v && s3_id == m_bid));

  assert_fwd_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s2_mv && fwd[s2_id] |-> t_idx[s2_id] == (s3_v ? s3_idx : h_idx));

  assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_idx) && $stable(dout_cnt));

  assert_pool_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !din_ready);
endmodule

// File: tb/sim_ooo_counter_incr.sv
module sim_ooo_counter_incr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        din_valid = 1'b0, din_ready;
  logic [28:0] din_idx = '0;
  logic        dout_valid, dout_ready = 1'b0;
  logic [28:0] dout_idx;
  logic [31:0] dout_cnt;
  logic        m_arvalid, m_arready = 1'b0;
  logic [31:0] m_araddr;
  logic [5:0]  m_arid;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst;
  logic        m_rvalid = 1'b0, m_rready;
  logic [5:0]  m_rid = '0;
  logic [63:0] m_rdata = '0;
  logic        m_awvalid, m_awready = 1'b0;
  logic [31:0] m_awaddr;
  logic [5:0]  m_awid;
  logic [7:0]  m_awlen;
  logic [2:0]  m_awsize;
  logic [1:0]  m_awburst;
  logic        m_wvalid, m_wready = 1'b0;
  logic [63:0] m_wdata;
  logic [7:0]  m_wstrb;
  logic        m_wlast;
  logic        m_bvalid = 1'b0, m_bready;
  logic [5:0]  m_bid = '0;

  ooo_counter_incr u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0]   mem [64];
  logic [31:0]   base [64];
  int            issued [64], seen [64];
  logic [1023:0] hits [64];
  int rq_n = 0, bq_n = 0;
  logic [5:0]  rq_id [64];
  logic [31:0] rq_addr [64];
  logic [5:0]  bq_id [64];
  bit r_en = 1, b_en = 1, rnd = 0;
  int ar_cnt = 0, acc_total = 0, out_total = 0;
  logic [31:0] last_araddr, last_awaddr;
  logic [7:0]  last_arlen, last_awlen;
  logic [2:0]  last_arsize;
  logic [1:0]  last_arburst;
  logic [63:0] last_wdata;
  logic [7:0]  last_wstrb;
  logic        last_wlast;
  logic [28:0] last_oidx;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_phase();
    for (int s = 0; s < 64; s++) begin
      base[s] = mem[s]; issued[s] = 0; seen[s] = 0; hits[s] = '0;
    end
  endtask

  task automatic end_phase(input string req);
    for (int s = 0; s < 64; s++)
      if (issued[s] != 0) begin
        chk(mem[s] == base[s] + issued[s], req, "final memory", mem[s], base[s] + issued[s]);
        chk(seen[s] == issued[s], "R2", "outputs per counter", seen[s], issued[s]);
      end
  endtask

  // memory model and monitors
  initial begin : slave
    int rp, bp;
    bit aw_p, w_p, hold;
    logic [5:0]  aw_i;
    logic [31:0] aw_a, w_d, off;
    logic [28:0] h_idx;
    logic [31:0] h_cnt;
    aw_p = 0; w_p = 0; hold = 0; rp = 0; bp = 0;
    aw_i = '0; aw_a = '0; w_d = '0; h_idx = '0; h_cnt = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        m_arready = 0; m_awready = 0; m_wready = 0; m_rvalid = 0; m_bvalid = 0; dout_ready = 0;
        continue;
      end
      m_arready  = rnd ? ($urandom % 3 != 0) : 1'b1;
      m_awready  = rnd ? ($urandom % 4 != 0) : 1'b1;
      m_wready   = rnd ? ($urandom % 4 != 0) : 1'b1;
      dout_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
      m_rvalid = 0;
      if (r_en && rq_n > 0 && (!rnd || $urandom % 2 == 0)) begin
        rp = $urandom % rq_n;
        m_rvalid = 1; m_rid = rq_id[rp];
        m_rdata = {32'h0, mem[rq_addr[rp][8:3]]};
      end
      m_bvalid = 0;
      if (b_en && bq_n > 0 && (!rnd || $urandom % 2 == 0)) begin
        bp = $urandom % bq_n;
        m_bvalid = 1; m_bid = bq_id[bp];
      end
      #1;
      if (hold) begin
        chk(dout_valid && dout_idx == h_idx && dout_cnt == h_cnt, "R10", "held output",
            dout_cnt, h_cnt);
      end
      hold = dout_valid && !dout_ready;
      h_idx = dout_idx; h_cnt = dout_cnt;
      if (hold) chk(!m_bready, "R10", "bready while output waits", m_bready, 0);
      if (m_arvalid && m_arready) begin
        rq_id[rq_n] = m_arid; rq_addr[rq_n] = m_araddr; rq_n++; ar_cnt++;
        last_araddr = m_araddr; last_arlen = m_arlen; last_arsize = m_arsize;
        last_arburst = m_arburst;
      end
      if (m_awvalid && m_awready) begin
        aw_p = 1; aw_i = m_awid; aw_a = m_awaddr; last_awaddr = m_awaddr; last_awlen = m_awlen;
      end
      if (m_wvalid && m_wready) begin
        w_p = 1; w_d = m_wdata[31:0];
        last_wdata = m_wdata; last_wstrb = m_wstrb; last_wlast = m_wlast;
      end
      if (aw_p && w_p) begin
        mem[aw_a[8:3]] = w_d; bq_id[bq_n] = aw_i; bq_n++; aw_p = 0; w_p = 0;
      end
      if (m_rvalid) begin
        if (!m_rready) chk(0, "R6", "rready", m_rready, 1);
        rq_id[rp] = rq_id[rq_n-1]; rq_addr[rp] = rq_addr[rq_n-1]; rq_n--;
      end
      if (m_bvalid && m_bready) begin
        bq_id[bp] = bq_id[bq_n-1]; bq_n--;
      end
      if (dout_valid && dout_ready) begin
        off = dout_cnt - base[dout_idx[5:0]];
        chk(off >= 1 && off <= issued[dout_idx[5:0]] && off < 1024 &&
            !hits[dout_idx[5:0]][off[9:0]], "R6", "output value offset", off,
            issued[dout_idx[5:0]]);
        if (off < 1024) hits[dout_idx[5:0]][off[9:0]] = 1'b1;
        seen[dout_idx[5:0]]++; out_total++; last_oidx = dout_idx;
      end
    end
  end

  task automatic send(input logic [28:0] idx);
    bit acc;
    din_valid = 1; din_idx = idx;
    forever begin
      #1; acc = din_ready;
      if (acc) begin issued[idx[5:0]]++; acc_total++; end
      @(negedge clk);
      if (acc) break;
    end
    din_valid = 0;
  endtask

  task automatic drain();
    while (acc_total != out_total) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic probe_ready(input logic [28:0] idx, input bit exp, input string req);
    din_valid = 0; din_idx = idx; #1;
    chk(din_ready == exp, req, "din_ready", din_ready, exp);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int a0, o0;
    for (int s = 0; s < 64; s++) mem[s] = 100 + 7 * s;
    begin_phase();
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(!m_arvalid && !m_awvalid && !m_wvalid, "R1", "bus valids", m_arvalid, 0);
    chk(!dout_valid, "R1", "dout_valid", dout_valid, 0);
    chk(din_ready, "R1", "din_ready", din_ready, 1);
    @(negedge clk);

    // R2/R3/R4 single request
    begin_phase();
    send(29'd3);
    drain();
    chk(last_araddr == 32'd24, "R3", "araddr", last_araddr, 24);
    chk(last_awaddr == 32'd24, "R3", "awaddr", last_awaddr, 24);
    chk(mem[3] == 32'd122, "R2", "memory after increment", mem[3], 122);
    chk(last_oidx == 29'd3, "R2", "output index", last_oidx, 3);
    end_phase("R2");

    // R3/R4 top index, burst fields, write data
    begin_phase();
    send(29'h1FFFFFF5);
    drain();
    chk(last_araddr == 32'hFFFFFFA8, "R3", "high araddr", last_araddr, 32'hFFFFFFA8);
    chk(last_awaddr == 32'hFFFFFFA8, "R3", "high awaddr", last_awaddr, 32'hFFFFFFA8);
    chk(last_arlen == 0 && last_awlen == 0, "R3", "burst length", last_arlen, 0);
    chk(last_arsize == 3, "R3", "size code", last_arsize, 3);
    chk(last_arburst == 1, "R3", "burst code", last_arburst, 1);
    chk(last_wdata[63:32] == 0, "R4", "write upper half", last_wdata[63:32], 0);
    chk(last_wdata[31:0] == base[53] + 1, "R4", "write low half", last_wdata[31:0], base[53] + 1);
    chk(last_wstrb == 8'hFF && last_wlast, "R4", "strobes", last_wstrb, 8'hFF);
    chk(last_oidx == 29'h1FFFFFF5, "R2", "high output index", last_oidx, 29'h1FFFFFF5);
    end_phase("R6");

    // R5 output waits for write response
    begin_phase();
    b_en = 0; o0 = out_total;
    send(29'd9);
    repeat (30) @(negedge clk);
    chk(bq_n == 1, "R5", "write accepted by memory", bq_n, 1);
    chk(out_total == o0 && !dout_valid, "R5", "outputs before response", out_total - o0, 0);
    b_en = 1;
    drain();
    end_phase("R5");

    // R7 back-to-back same counter forwards
    begin_phase();
    b_en = 0; a0 = ar_cnt;
    send(29'd12); send(29'd12); send(29'd12);
    repeat (30) @(negedge clk);
    chk(ar_cnt - a0 == 1, "R7", "reads for a chain of three", ar_cnt - a0, 1);
    b_en = 1;
    drain();
    end_phase("R7");

    // R8 non-adjacent collision is held off
    begin_phase();
    b_en = 0;
    send(29'd20); send(29'd21);
    repeat (20) @(negedge clk);
    probe_ready(29'd20, 0, "R8");
    probe_ready(29'd22, 1, "R8");
    b_en = 1;
    send(29'd20);
    drain();
    end_phase("R8");

    // R9 ID pool exhaustion
    begin_phase();
    b_en = 0; a0 = ar_cnt;
    for (int i = 0; i < 64; i++) send(i[28:0]);
    repeat (40) @(negedge clk);
    chk(ar_cnt - a0 == 64, "R9", "reads issued", ar_cnt - a0, 64);
    probe_ready(29'd64, 0, "R9");
    b_en = 1;
    drain();
    end_phase("R9");
    begin_phase();
    send(29'd64);
    drain();
    end_phase("R9");

    // R6/R10 random sweeps, heavy and light collision
    rnd = 1;
    begin_phase();
    for (int i = 0; i < 500; i++) send(29'($urandom % 4));
    drain();
    end_phase("R6");
    begin_phase();
    for (int i = 0; i < 500; i++) send(29'($urandom % 8 + 40));
    drain();
    end_phase("R6");
    rnd = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule